// File: doc/BRIEF.md
# Byte Register ALU With Flag

This block is the execute stage of a small 8-bit virtual-machine processor. It owns the sixteen general registers, numbered 0 to 15. Register 15 also serves as the flag register. Each accepted operation names a destination index X, a source index Y, an 8-bit immediate, an operation class and a 4-bit sub-operation. In a single clock edge the block writes the result into register X and, for operations that make a flag, writes that flag into register 15.

Operations arrive on a valid/ready stream. `op_ready` is held high at all times, including during reset, so the block never applies back-pressure. An operation is taken on every rising edge where `op_valid` is high and reset is low. When `op_valid` is low, the other operation inputs are ignored. All sixteen registers are exposed on a flat read bus so that neighbouring logic, or a bench, can watch them.

Operation classes are: 0 = register-register ALU (the sub-operation selects the function), 1 = load immediate, 2 = add immediate, 3 = reserved.

Top module: `byte_reg_alu`

## Requirements
- R1: A synchronous reset clears all sixteen registers to 0 and holds `illegal_op` low. `op_ready` reads 1.
- R2: In class 0, sub 0 copies VY into VX, sub 1 ORs VY into VX, sub 2 ANDs VY into VX, and sub 3 XORs VY into VX. None of these alters register 15 unless X is 15.
- R3: When X equals Y, sub 3 clears VX, while sub 1 and sub 2 leave VX at its old value.
- R4: Sub 4 writes (VX+VY) mod 256 into VX and sets register 15 to the carry out, either 0 or 1.
- R5: Sub 5 writes VX-VY into VX and sub 7 writes VY-VX into VX, both mod 256. Register 15 becomes 1 when the minuend is not smaller than the subtrahend, and 0 otherwise.
- R6: Sub 6 shifts VX right by one and puts the old bit 0 into register 15. Sub 14 (0xE) shifts VX left by one and puts the old bit 7 into register 15.
- R7: For a flag-making operation (sub 4, 5, 6, 7 or 0xE) with X = 15, register 15 ends up holding only the flag. The arithmetic result is dropped.
- R8: Both operands are the register values from before the edge. A source of register 15 reads the old flag, and X = Y uses the old value twice.
- R9: Class 1 writes the immediate into VX.
- R10: Class 2 writes (VX+imm) mod 256 into VX and leaves register 15 alone when X is not 15.
- R11: Class 3, or class 0 with sub 8 to 13 or 15, changes no register and raises `illegal_op` for exactly the one cycle after the edge that accepted it.
- R12: With `op_valid` low, no register changes and `illegal_op` stays low, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_ready | output | 1 | Always 1: operation accepted whenever valid |
| op_class | input | 2 | 0 ALU, 1 load immediate, 2 add immediate, 3 reserved |
| op_sub | input | 4 | ALU sub-operation for class 0 |
| op_x | input | 4 | Destination / first operand index |
| op_y | input | 4 | Second operand index |
| op_imm | input | 8 | Immediate byte |
| regs_flat | output | 128 | Register i on bits [8i+7:8i] |
| illegal_op | output | 1 | One-cycle pulse after an unknown operation |

## Verification
The bench targets the cases where destination and flag collide.

- With X = 15, a design that let the result win would leave a sum or a difference in register 15 instead of a 0/1 flag.
- Subtraction with equal operands must give a flag of 1. A design with a plain borrow flag, or with a strict comparison, would show 0.
- When register 15 is itself a source, or X equals Y, the old values must be used. A design that read back newly written state would produce a different sum.
- Illegal codes and idle cycles carry busy immediates and indices. Any write leaking through would show up as a changed register, and a pulse sent at the wrong time would show up on `illegal_op`.

// File: rtl/bra_pkg.sv
package bra_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_LDI = 2'd1,
    CLS_ADI = 2'd2,
    CLS_RSV = 2'd3
  } op_class_e;

  localparam logic [3:0] SUB_MOV  = 4'h0;
  localparam logic [3:0] SUB_OR   = 4'h1;
  localparam logic [3:0] SUB_AND  = 4'h2;
  localparam logic [3:0] SUB_XOR  = 4'h3;
  localparam logic [3:0] SUB_ADD  = 4'h4;
  localparam logic [3:0] SUB_SUBF = 4'h5;
  localparam logic [3:0] SUB_SHR  = 4'h6;
  localparam logic [3:0] SUB_SUBR = 4'h7;
  localparam logic [3:0] SUB_SHL  = 4'hE;
endpackage

// File: rtl/bra_alu_core.sv
module bra_alu_core
  import bra_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   cls,
  input  logic [3:0]   sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] imm,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [W-1:0] flag,
  output logic         flag_we,
  output logic         legal
);
  logic [W:0] sum_ab;
  logic [W:0] sum_ai;
  logic       flag_bit;

  assign sum_ab = {1'b0, a} + {1'b0, b};
  assign sum_ai = {1'b0, a} + {1'b0, imm};
  assign flag   = {{(W-1){1'b0}}, flag_bit};

  always_comb begin
    res      = a;
    res_we   = 1'b0;
    flag_bit = 1'b0;
    flag_we  = 1'b0;
    legal    = 1'b1;
    unique case (op_class_e'(cls))
      CLS_ALU: begin
        res_we = 1'b1;
        case (sub)
          SUB_MOV: res = b;
          SUB_OR:  res = a | b;
          SUB_AND: res = a & b;
          SUB_XOR: res = a ^ b;
          SUB_ADD: begin
            res = sum_ab[W-1:0];
            flag_bit = sum_ab[W];
            flag_we = 1'b1;
          end
          SUB_SUBF: begin
            res = a - b;
            flag_bit = (a >= b);
            flag_we = 1'b1;
          end
          SUB_SUBR: begin
            res = b - a;
            flag_bit = (b >= a);
            flag_we = 1'b1;
          end
          SUB_SHR: begin
            res = a >> 1;
            flag_bit = a[0];
            flag_we = 1'b1;
          end
          SUB_SHL: begin
            res = a << 1;
            flag_bit = a[W-1];
            flag_we = 1'b1;
          end
          default: begin
            res_we = 1'b0;
            legal = 1'b0;
          end
        endcase
      end
      CLS_LDI: begin
        res = imm;
        res_we = 1'b1;
      end
      CLS_ADI: begin
        res = sum_ai[W-1:0];
        res_we = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/bra_reg_file.sv
module bra_reg_file #(
  parameter int W = 8,
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             fl_en,
  input  logic [W-1:0]     fl_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [W-1:0]     rd_a,
  output logic [W-1:0]     rd_b,
  output logic [N*W-1:0]   flat
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (fl_en && (i == N-1))
        q <= fl_data;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        q <= wr_data;
    end
    assign flat[i*W +: W] = q;
  end

  assign rd_a = flat[rd_a_idx*W +: W];
  assign rd_b = flat[rd_b_idx*W +: W];
endmodule

// File: rtl/byte_reg_alu.sv
module byte_reg_alu #(
  parameter int W = 8,
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [1:0]       op_class,
  input  logic [3:0]       op_sub,
  input  logic [IDX_W-1:0] op_x,
  input  logic [IDX_W-1:0] op_y,
  input  logic [W-1:0]     op_imm,
  output logic [N*W-1:0]   regs_flat,
  output logic             illegal_op
);
  logic [W-1:0] va, vb, res, flag;
  logic         res_we, flag_we, legal, take;

  assign op_ready = 1'b1;
  assign take     = op_valid;

  bra_reg_file #(.W(W), .N(N)) rf_i (
    .clk(clk), .rst(rst),
    .wr_en(take && res_we), .wr_idx(op_x), .wr_data(res),
    .fl_en(take && flag_we), .fl_data(flag),
    .rd_a_idx(op_x), .rd_b_idx(op_y),
    .rd_a(va), .rd_b(vb), .flat(regs_flat)
  );

  bra_alu_core #(.W(W)) alu_i (
    .cls(op_class), .sub(op_sub), .a(va), .b(vb), .imm(op_imm),
    .res(res), .res_we(res_we), .flag(flag), .flag_we(flag_we), .legal(legal)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_op <= 1'b0;
    else     illegal_op <= take && !legal;
  end
endmodule

// File: rtl/byte_reg_alu_chk.sv
module byte_reg_alu_chk #(
  parameter int W = 8,
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_class,
  input logic [3:0]       op_sub,
  input logic [IDX_W-1:0] op_x,
  input logic [IDX_W-1:0] op_y,
  input logic [W-1:0]     op_imm,
  input logic [N*W-1:0]   regs_flat,
  input logic             illegal_op
);
  function automatic logic [W-1:0] vbyte(input logic [N*W-1:0] f, input logic [IDX_W-1:0] i);
    return f[i*W +: W];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) && !rst |-> (regs_flat == '0) && !illegal_op) else $error("reset"); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !$past(rst) && !$past(op_valid) |-> $stable(regs_flat) && !illegal_op) else $error("idle"); // R12
  AST_ILLEGAL_CLASS: assert property (@(posedge clk) disable iff (rst) !$past(rst) && $past(op_valid) && $past(op_class) == 2'd3 |-> illegal_op && $stable(regs_flat)) else $error("illegal"); // R11
  AST_LOAD_IMM: assert property (@(posedge clk) disable iff (rst) !$past(rst) && $past(op_valid) && $past(op_class) == 2'd1 |-> vbyte(regs_flat, $past(op_x)) == $past(op_imm)) else $error("ldi"); // R9
  AST_ADDI_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst) !$past(rst) && $past(op_valid) && $past(op_class) == 2'd2 && $past(op_x) != IDX_W'(N-1) |-> vbyte(regs_flat, IDX_W'(N-1)) == $past(vbyte(regs_flat, IDX_W'(N-1)))) else $error("adi vf"); // R10
  AST_FLAG_DEST_BIT: assert property (@(posedge clk) disable iff (rst) !$past(rst) && $past(op_valid) && $past(op_class) == 2'd0 && $past(op_x) == IDX_W'(N-1) && ($past(op_sub) inside {4'h4, 4'h5, 4'h6, 4'h7, 4'hE}) |-> vbyte(regs_flat, IDX_W'(N-1)) <= 1) else $error("vf dest"); // R7
  AST_READY_HIGH: assert property (@(posedge clk) op_ready) else $error("ready"); // R1
endmodule

bind byte_reg_alu byte_reg_alu_chk #(.W(W), .N(N)) chk_i (.*);

// File: tb/byte_reg_alu_tb_top.sv
`timescale 1ns/1ps
module byte_reg_alu_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic op_ready;
  logic [1:0] op_class = '0;
  logic [3:0] op_sub = '0, op_x = '0, op_y = '0;
  logic [7:0] op_imm = '0;
  logic [127:0] regs_flat;
  logic illegal_op;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [7:0] m [16];

  always #2.5 clk = ~clk;

  byte_reg_alu dut_i (.*);

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input bit exp_ill);
    for (int i = 0; i < 16; i++) begin
      vectors++;
      if (regs_flat[i*8 +: 8] !== m[i]) begin
        miscompares++;
        $display("FAIL %s reg%0d actual=%0h expected=%0h", req, i, regs_flat[i*8 +: 8], m[i]);
      end
    end
    chk(req, "illegal_op", {7'd0, illegal_op}, {7'd0, exp_ill});
  endtask

  task automatic do_op(input logic [1:0] c, input logic [3:0] s, input logic [3:0] x,
                       input logic [3:0] y, input logic [7:0] imm, input bit v, input string req);
    logic [7:0] a, b, r;
    logic [8:0] t;
    bit ill, has_f;
    logic f;
    a = m[x]; b = m[y]; ill = 0; has_f = 0; f = 0; r = a;
    if (c == 2'd1) r = imm;
    else if (c == 2'd2) r = a + imm;
    else if (c == 2'd3) ill = 1;
    else begin
      case (s)
        4'h0: r = b;
        4'h1: r = a | b;
        4'h2: r = a & b;
        4'h3: r = a ^ b;
        4'h4: begin t = a + b; r = t[7:0]; f = t[8]; has_f = 1; end
        4'h5: begin r = a - b; f = !(b > a); has_f = 1; end
        4'h7: begin r = b - a; f = !(a > b); has_f = 1; end
        4'h6: begin r = {1'b0, a[7:1]}; f = a[0]; has_f = 1; end
        4'hE: begin r = {a[6:0], 1'b0}; f = a[7]; has_f = 1; end
        default: ill = 1;
      endcase
    end
    if (v && !ill) begin
      m[x] = r;
      if (has_f) m[15] = {7'd0, f};
    end
    @(negedge clk);
    op_valid = v; op_class = c; op_sub = s; op_x = x; op_y = y; op_imm = imm;
    @(negedge clk);
    op_valid = 0;
    check_all(req, v && ill);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    check_all("R1", 0);
    chk("R1", "op_ready", {7'd0, op_ready}, 8'd1);
  endtask

  task automatic t_load();
    for (int i = 0; i < 16; i++) do_op(2'd1, 0, i[3:0], 0, 8'h11 * i[7:0] + 8'h3, 1, "R9");
  endtask

  task automatic t_logic();
    do_op(2'd1, 0, 4'd1, 0, 8'hA5, 1, "R9");
    do_op(2'd1, 0, 4'd2, 0, 8'h3C, 1, "R9");
    do_op(2'd0, 4'h1, 4'd1, 4'd2, 8'hFF, 1, "R2");
    do_op(2'd0, 4'h2, 4'd1, 4'd2, 8'h00, 1, "R2");
    do_op(2'd0, 4'h3, 4'd1, 4'd5, 8'h00, 1, "R2");
    do_op(2'd0, 4'h0, 4'd3, 4'd1, 8'h00, 1, "R2");
    do_op(2'd0, 4'h0, 4'd15, 4'd2, 8'h00, 1, "R2");
  endtask

  task automatic t_self();
    do_op(2'd0, 4'h1, 4'd6, 4'd6, 0, 1, "R3");
    do_op(2'd0, 4'h2, 4'd6, 4'd6, 0, 1, "R3");
    do_op(2'd0, 4'h3, 4'd6, 4'd6, 0, 1, "R3");
  endtask

  task automatic t_add();
    do_op(2'd1, 0, 4'd1, 0, 8'hF0, 1, "R9");
    do_op(2'd1, 0, 4'd2, 0, 8'h20, 1, "R9");
    do_op(2'd0, 4'h4, 4'd1, 4'd2, 0, 1, "R4");
    do_op(2'd0, 4'h4, 4'd1, 4'd2, 0, 1, "R4");
    do_op(2'd1, 0, 4'd3, 0, 8'hFF, 1, "R9");
    do_op(2'd1, 0, 4'd4, 0, 8'h01, 1, "R9");
    do_op(2'd0, 4'h4, 4'd3, 4'd4, 0, 1, "R4");
  endtask

  task automatic t_sub();
    do_op(2'd1, 0, 4'd1, 0, 8'h40, 1, "R9");
    do_op(2'd1, 0, 4'd2, 0, 8'h40, 1, "R9");
    do_op(2'd0, 4'h5, 4'd1, 4'd2, 0, 1, "R5");
    do_op(2'd0, 4'h5, 4'd1, 4'd2, 0, 1, "R5");
    do_op(2'd1, 0, 4'd1, 0, 8'h10, 1, "R9");
    do_op(2'd0, 4'h7, 4'd1, 4'd2, 0, 1, "R5");
    do_op(2'd0, 4'h7, 4'd2, 4'd1, 0, 1, "R5");
    do_op(2'd0, 4'h7, 4'd2, 4'd2, 0, 1, "R5");
  endtask

  task automatic t_shift();
    do_op(2'd1, 0, 4'd5, 0, 8'h81, 1, "R9");
    do_op(2'd0, 4'h6, 4'd5, 0, 0, 1, "R6");
    do_op(2'd0, 4'h6, 4'd5, 0, 0, 1, "R6");
    do_op(2'd1, 0, 4'd5, 0, 8'h81, 1, "R9");
    do_op(2'd0, 4'hE, 4'd5, 0, 0, 1, "R6");
    do_op(2'd0, 4'hE, 4'd5, 0, 0, 1, "R6");
  endtask

  task automatic t_flag_dest();
    do_op(2'd1, 0, 4'd15, 0, 8'hC0, 1, "R9");
    do_op(2'd1, 0, 4'd1, 0, 8'h80, 1, "R9");
    do_op(2'd0, 4'h4, 4'd15, 4'd1, 0, 1, "R7");
    do_op(2'd1, 0, 4'd15, 0, 8'h90, 1, "R9");
    do_op(2'd0, 4'h5, 4'd15, 4'd1, 0, 1, "R7");
    do_op(2'd1, 0, 4'd15, 0, 8'h02, 1, "R9");
    do_op(2'd0, 4'h6, 4'd15, 0, 0, 1, "R7");
    do_op(2'd1, 0, 4'd15, 0, 8'h7F, 1, "R9");
    do_op(2'd0, 4'hE, 4'd15, 0, 0, 1, "R7");
    do_op(2'd1, 0, 4'd15, 0, 8'h05, 1, "R9");
    do_op(2'd0, 4'h7, 4'd15, 4'd1, 0, 1, "R7");
  endtask

  task automatic t_sampling();
    do_op(2'd1, 0, 4'd15, 0, 8'h01, 1, "R9");
    do_op(2'd1, 0, 4'd3, 0, 8'hFF, 1, "R9");
    do_op(2'd0, 4'h4, 4'd3, 4'd15, 0, 1, "R8");
    do_op(2'd1, 0, 4'd4, 0, 8'h80, 1, "R9");
    do_op(2'd0, 4'h4, 4'd4, 4'd4, 0, 1, "R8");
    chk("R8", "reg4", regs_flat[39:32], 8'h00);
    chk("R8", "reg15", regs_flat[127:120], 8'h01);
  endtask

  task automatic t_addi();
    do_op(2'd1, 0, 4'd15, 0, 8'h5A, 1, "R9");
    do_op(2'd1, 0, 4'd7, 0, 8'hF8, 1, "R9");
    do_op(2'd2, 0, 4'd7, 0, 8'h10, 1, "R10");
    do_op(2'd2, 0, 4'd7, 0, 8'h01, 1, "R10");
    chk("R10", "reg15", regs_flat[127:120], 8'h5A);
  endtask

  task automatic t_illegal();
    do_op(2'd3, 4'h0, 4'd2, 4'd3, 8'hEE, 1, "R11");
    for (int s = 8; s <= 15; s++)
      if (s != 14) do_op(2'd0, s[3:0], 4'd15, 4'd2, 8'hEE, 1, "R11");
    @(negedge clk);
    chk("R11", "illegal_op after pulse", {7'd0, illegal_op}, 8'd0);
  endtask

  task automatic t_idle();
    do_op(2'd1, 0, 4'd9, 0, 8'h77, 0, "R12");
    do_op(2'd0, 4'h4, 4'd15, 4'd9, 0, 0, "R12");
    do_op(2'd3, 0, 4'd9, 0, 0, 0, "R12");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_load();
    t_logic();
    t_self();
    t_add();
    t_sub();
    t_shift();
    t_flag_dest();
    t_sampling();
    t_addi();
    t_illegal();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule